// File: doc/BRIEF.md
# Double-Buffered ROM Emulation Controller

This block stands in for a read-only program memory seen by a target controller. It keeps two full copies of the image in one RAM and shows the target exactly one of them, the active bank. A host edits the other bank through its own port, then requests a swap. The swap makes the whole new image visible to the target at once, so the target never sees a half-edited table set.

Each swap starts a resync copy from the fresh active bank into the stale one. Afterwards both banks match again, and the next download only has to carry the bytes that changed. Reset is treated as a cold start: the image is loaded from an external backing ROM into both banks. A wake pulse re-verifies the active bank against the retained 16-bit checksum. If the sum does not match, a reload from the ROM starts.

The RAM word address is `{target_address, bank}`, so the bank select is the lowest RAM address bit and the two images are interleaved. A wider target address bus is served by connecting only its low `BA_W` bits; any further upper bits are simply dropped.

Top module: `romemu_ctrl`

## Requirements
- R1: The RAM word address for a target read is `{tgt_addr, active_bank}`, and the host port addresses word `{h_addr, h_bank}`. A read of host bank b at address a therefore returns what the target sees at address a while b is active.
- R2: A target access cycle requires both `tgt_cs_n`=0 and `tgt_cs`=1. `tgt_data` shows the active bank's byte at `tgt_addr` in the cycle after the access cycle.
- R3: When idle, a host write (`h_req`=1, `h_we`=1) to the inactive bank stores `h_wdata` and leaves `h_err` at 0 in the next cycle. A write to the active bank is rejected: memory is unchanged and `h_err` is 1 in the next cycle.
- R4: A one-cycle `h_swap` pulse is latched. The active bank toggles on the first clock edge, at least one cycle after the pulse, at which the block is not busy and no target access cycle is in progress. Until then `st_bank` is unchanged.
- R5: Each swap starts a copy of every word of the new active bank into the new inactive bank. `st_busy` is 1 for exactly 2·2^BA_W cycles, beginning in the cycle after the swap edge.
- R6: While `st_busy` is 1, host requests are ignored: no write lands and `h_err` stays 0. Pending swaps wait until busy falls.
- R7: After reset, `st_bank`=0 and `st_reload_done`=0, and the block is busy loading ROM words 0..2^BA_W−1 into both banks. At the end, `st_reload_done`=1 and `st_csum_ok`=1. `rom_data` is expected one cycle after `rom_addr`.
- R8: The checksum is the 16-bit sum, modulo 2^16, of all bytes of the active bank. It is stored at the end of each reload and each resync copy. A `wake` pulse while idle recomputes it over the active bank and clears `st_reload_done`. On a match `st_csum_ok`=1 and no reload occurs; on a mismatch `st_csum_ok`=0 and a reload starts.
- R9: `h_rdata` shows the addressed byte of either bank in the cycle after an idle host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts the cold reload |
| tgt_addr | input | BA_W | Target ROM address |
| tgt_cs_n | input | 1 | Target enable, active low |
| tgt_cs | input | 1 | Target enable, active high |
| tgt_data | output | DW | Target read data, one cycle latency |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_bank | input | 1 | Host bank select |
| h_addr | input | BA_W | Host word address within the bank |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, one cycle latency |
| h_err | output | 1 | Write to active bank rejected |
| h_swap | input | 1 | Swap request pulse |
| wake | input | 1 | Start checksum verification |
| rom_addr | output | BA_W | Backing ROM address |
| rom_data | input | DW | Backing ROM data, one cycle after address |
| st_bank | output | 1 | Active bank |
| st_busy | output | 1 | Copy, reload or verify in progress |
| st_csum_ok | output | 1 | Last checksum check or store succeeded |
| st_reload_done | output | 1 | Last image came from the backing ROM |

## Verification
A wrong bank bit shows up on the very next target read as a byte from the edited image, or as a write that lands in the visible bank. A swap taken during a read, or while busy, appears as an `st_bank` change within one cycle. A resync copy that skips or misdirects words leaves the stale bank different from the active one; host reads of the stale bank reveal this as soon as busy falls. A miscounted engine changes the length of the busy window, which is counted cycle by cycle. A wrong checksum or verify path triggers an unwanted reload on wake, which replaces the image with a different ROM pattern.

// File: rtl/romemu_pkg.sv
package romemu_pkg;
  localparam int CSW = 16;

  typedef enum logic [2:0] {
    E_IDLE,
    E_CP_RD,
    E_CP_WR,
    E_RL_A,
    E_RL_W0,
    E_RL_W1,
    E_VF_RD,
    E_VF_AC
  } eng_st_t;
endpackage

// File: rtl/romemu_ram.sv
module romemu_ram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-only port for the target
  always_ff @(posedge clk) begin
    if (rst)       a_q <= '0;
    else if (a_en) a_q <= mem[a_addr];
  end

  // read/write port shared by host and engine
  always_ff @(posedge clk) begin
    if (b_en && b_we) mem[b_addr] <= b_wd;
  end

  always_ff @(posedge clk) begin
    if (rst)                b_q <= '0;
    else if (b_en && !b_we) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/romemu_bank.sv
module romemu_bank (
  input  logic clk,
  input  logic rst,
  input  logic swap_req,
  input  logic busy,
  input  logic tgt_act,
  output logic bank,
  output logic swap_fire
);
  logic pend;

  assign swap_fire = pend & ~busy & ~tgt_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      bank <= 1'b0;
    end else begin
      pend <= (pend & ~swap_fire) | swap_req;
      if (swap_fire) bank <= ~bank;
    end
  end
endmodule

// File: rtl/romemu_engine.sv
module romemu_engine
  import romemu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int BA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bank,
  input  logic            go_copy,
  input  logic            wake,
  output logic [BA_W-1:0] rom_addr,
  input  logic [DW-1:0]   rom_data,
  output logic            b_en,
  output logic            b_we,
  output logic [BA_W:0]   b_addr,
  output logic [DW-1:0]   b_wd,
  input  logic [DW-1:0]   b_q,
  output logic            busy,
  output logic            csum_ok,
  output logic            reload_done
);
  localparam int NW = 1 << BA_W;
  localparam logic [BA_W-1:0] LAST = BA_W'(NW - 1);

  eng_st_t         st;
  logic [BA_W-1:0] idx;
  logic [CSW-1:0]  sum, stored;
  logic [DW-1:0]   hold;
  logic [CSW-1:0]  sum_q, sum_h;
  logic            last;

  assign last     = (idx == LAST);
  assign sum_q    = sum + CSW'(b_q);
  assign sum_h    = sum + CSW'(hold);
  assign busy     = (st != E_IDLE);
  assign rom_addr = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= E_RL_A;
      idx         <= '0;
      sum         <= '0;
      stored      <= '0;
      hold        <= '0;
      csum_ok     <= 1'b0;
      reload_done <= 1'b0;
    end else begin
      case (st)
        E_IDLE: begin
          if (go_copy) begin
            st  <= E_CP_RD;
            idx <= '0;
            sum <= '0;
          end else if (wake) begin
            st          <= E_VF_RD;
            idx         <= '0;
            sum         <= '0;
            reload_done <= 1'b0;
          end
        end
        E_CP_RD: st <= E_CP_WR;
        E_CP_WR: begin
          sum <= sum_q;
          if (last) begin
            stored  <= sum_q;
            csum_ok <= 1'b1;
            st      <= E_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= E_CP_RD;
          end
        end
        E_RL_A: st <= E_RL_W0;
        E_RL_W0: begin
          hold <= rom_data;
          st   <= E_RL_W1;
        end
        E_RL_W1: begin
          sum <= sum_h;
          if (last) begin
            stored      <= sum_h;
            csum_ok     <= 1'b1;
            reload_done <= 1'b1;
            st          <= E_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= E_RL_A;
          end
        end
        E_VF_RD: st <= E_VF_AC;
        E_VF_AC: begin
          sum <= sum_q;
          if (last) begin
            if (sum_q == stored) begin
              csum_ok <= 1'b1;
              st      <= E_IDLE;
            end else begin
              csum_ok <= 1'b0;
              idx     <= '0;
              sum     <= '0;
              st      <= E_RL_A;
            end
          end else begin
            idx <= idx + 1'b1;
            st  <= E_VF_RD;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    b_en   = 1'b0;
    b_we   = 1'b0;
    b_addr = {idx, bank};
    b_wd   = b_q;
    case (st)
      E_CP_RD: b_en = 1'b1;
      E_CP_WR: begin
        b_en   = 1'b1;
        b_we   = 1'b1;
        b_addr = {idx, ~bank};
      end
      E_RL_W0: begin
        b_en   = 1'b1;
        b_we   = 1'b1;
        b_addr = {idx, 1'b0};
        b_wd   = rom_data;
      end
      E_RL_W1: begin
        b_en   = 1'b1;
        b_we   = 1'b1;
        b_addr = {idx, 1'b1};
        b_wd   = hold;
      end
      E_VF_RD: b_en = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/romemu_ctrl.sv
module romemu_ctrl #(
  parameter int DW   = 8,
  parameter int BA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BA_W-1:0] tgt_addr,
  input  logic            tgt_cs_n,
  input  logic            tgt_cs,
  output logic [DW-1:0]   tgt_data,
  input  logic            h_req,
  input  logic            h_we,
  input  logic            h_bank,
  input  logic [BA_W-1:0] h_addr,
  input  logic [DW-1:0]   h_wdata,
  output logic [DW-1:0]   h_rdata,
  output logic            h_err,
  input  logic            h_swap,
  input  logic            wake,
  output logic [BA_W-1:0] rom_addr,
  input  logic [DW-1:0]   rom_data,
  output logic            st_bank,
  output logic            st_busy,
  output logic            st_csum_ok,
  output logic            st_reload_done
);
  localparam int RAW = BA_W + 1;

  logic           tgt_act, bank, swap_fire, busy;
  logic           e_en, e_we;
  logic [RAW-1:0] e_addr;
  logic [DW-1:0]  e_wd;
  logic           b_en, b_we;
  logic [RAW-1:0] b_addr;
  logic [DW-1:0]  b_wd, b_q;
  logic           h_ok, h_hit_act;

  assign tgt_act   = ~tgt_cs_n & tgt_cs;
  assign h_ok      = h_req & ~busy;
  assign h_hit_act = (h_bank == bank);

  romemu_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .swap_req (h_swap),
    .busy     (busy),
    .tgt_act  (tgt_act),
    .bank     (bank),
    .swap_fire(swap_fire)
  );

  romemu_engine #(.DW(DW), .BA_W(BA_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .bank       (bank),
    .go_copy    (swap_fire),
    .wake       (wake),
    .rom_addr   (rom_addr),
    .rom_data   (rom_data),
    .b_en       (e_en),
    .b_we       (e_we),
    .b_addr     (e_addr),
    .b_wd       (e_wd),
    .b_q        (b_q),
    .busy       (busy),
    .csum_ok    (st_csum_ok),
    .reload_done(st_reload_done)
  );

  // port B: engine owns it while busy, host otherwise
  always_comb begin
    if (busy) begin
      b_en   = e_en;
      b_we   = e_we;
      b_addr = e_addr;
      b_wd   = e_wd;
    end else begin
      b_en   = h_ok & ~(h_we & h_hit_act);
      b_we   = h_we;
      b_addr = {h_addr, h_bank};
      b_wd   = h_wdata;
    end
  end

  romemu_ram #(.DW(DW), .AW(RAW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .a_en  (tgt_act),
    .a_addr({tgt_addr, bank}),
    .a_q   (tgt_data),
    .b_en  (b_en),
    .b_we  (b_we),
    .b_addr(b_addr),
    .b_wd  (b_wd),
    .b_q   (b_q)
  );

  always_ff @(posedge clk) begin
    if (rst) h_err <= 1'b0;
    else     h_err <= h_ok & h_we & h_hit_act;
  end

  assign h_rdata = b_q;
  assign st_bank = bank;
  assign st_busy = busy;
endmodule

// File: rtl/romemu_ctrl_chk.sv
module romemu_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tgt_cs_n,
  input logic          tgt_cs,
  input logic [DW-1:0] tgt_data,
  input logic          h_req,
  input logic          h_we,
  input logic          h_bank,
  input logic          h_err,
  input logic          st_bank,
  input logic          st_busy,
  input logic          st_csum_ok,
  input logic          st_reload_done
);
  // R4: no bank change while busy or while the target is reading
  a_r4_bank_hold: assert property (@(posedge clk) disable iff (rst)
    (st_busy || (!tgt_cs_n && tgt_cs)) |=> (st_bank == $past(st_bank)));

  // R5: every swap is followed by a busy resync copy
  a_r5_copy_on_swap: assert property (@(posedge clk) disable iff (rst)
    (st_bank != $past(st_bank)) |-> st_busy);

  // R3: an idle write to the active bank is flagged
  a_r3_err_active: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_we && !st_busy && (h_bank == st_bank)) |=> h_err);

  // R6: no error flag without an idle active-bank write
  a_r6_no_err: assert property (@(posedge clk) disable iff (rst)
    (!h_req || !h_we || st_busy || (h_bank != st_bank)) |=> !h_err);

  // R2: output holds when either enable is deasserted
  a_r2_hold_data: assert property (@(posedge clk) disable iff (rst)
    (tgt_cs_n || !tgt_cs) |=> $stable(tgt_data));

  // R8: a reloaded image always carries a good checksum
  a_r8_done_ok: assert property (@(posedge clk) disable iff (rst)
    st_reload_done |-> st_csum_ok);
endmodule

bind romemu_ctrl romemu_ctrl_chk #(.DW(DW)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .tgt_cs_n      (tgt_cs_n),
  .tgt_cs        (tgt_cs),
  .tgt_data      (tgt_data),
  .h_req         (h_req),
  .h_we          (h_we),
  .h_bank        (h_bank),
  .h_err         (h_err),
  .st_bank       (st_bank),
  .st_busy       (st_busy),
  .st_csum_ok    (st_csum_ok),
  .st_reload_done(st_reload_done)
);

// File: tb/test_romemu_ctrl.sv
`timescale 1ns/1ps
module test_romemu_ctrl;
  localparam int DW   = 8;
  localparam int BA_W = 5;
  localparam int NW   = 1 << BA_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [BA_W-1:0] tgt_addr = '0;
  logic            tgt_cs_n = 1'b1;
  logic            tgt_cs = 1'b0;
  logic [DW-1:0]   tgt_data;
  logic            h_req = 1'b0, h_we = 1'b0, h_bank = 1'b0;
  logic [BA_W-1:0] h_addr = '0;
  logic [DW-1:0]   h_wdata = '0;
  logic [DW-1:0]   h_rdata;
  logic            h_err;
  logic            h_swap = 1'b0, wake = 1'b0;
  logic [BA_W-1:0] rom_addr;
  logic [DW-1:0]   rom_data;
  logic            st_bank, st_busy, st_csum_ok, st_reload_done;
  int              rom_sel = 0;
  int              n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  function automatic int img_a(int a); return (a * 37 + 11) & 8'hFF; endfunction
  function automatic int img_b(int a); return ((a * 13) ^ 8'h5A) & 8'hFF; endfunction
  function automatic int img_c(int a); return (~(a * 7)) & 8'hFF; endfunction

  // backing ROM: data one cycle after address
  always_ff @(posedge clk)
    rom_data <= DW'((rom_sel == 0) ? img_a(int'(rom_addr)) : img_c(int'(rom_addr)));

  romemu_ctrl #(.DW(DW), .BA_W(BA_W)) i_romemu_ctrl (
    .clk(clk), .rst(rst), .tgt_addr(tgt_addr), .tgt_cs_n(tgt_cs_n), .tgt_cs(tgt_cs),
    .tgt_data(tgt_data), .h_req(h_req), .h_we(h_we), .h_bank(h_bank), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_err(h_err), .h_swap(h_swap), .wake(wake),
    .rom_addr(rom_addr), .rom_data(rom_data), .st_bank(st_bank), .st_busy(st_busy),
    .st_csum_ok(st_csum_ok), .st_reload_done(st_reload_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tgt_rd(input int a, output int d);
    tgt_addr = BA_W'(a); tgt_cs_n = 1'b0; tgt_cs = 1'b1;
    @(negedge clk);
    d = int'(tgt_data);
    tgt_cs_n = 1'b1; tgt_cs = 1'b0;
  endtask

  task automatic host_rd(input int b, input int a, output int d);
    h_req = 1'b1; h_we = 1'b0; h_bank = b[0]; h_addr = BA_W'(a);
    @(negedge clk);
    d = int'(h_rdata);
    h_req = 1'b0;
  endtask

  task automatic host_wr(input int b, input int a, input int v, output int e);
    h_req = 1'b1; h_we = 1'b1; h_bank = b[0]; h_addr = BA_W'(a); h_wdata = DW'(v);
    @(negedge clk);
    e = int'(h_err);
    h_req = 1'b0; h_we = 1'b0;
  endtask

  task automatic wait_idle(input int maxc);
    int n = 0;
    while (st_busy && n < maxc) begin
      @(negedge clk);
      n++;
    end
    if (st_busy) chk("busy watchdog", 1, 0);
  endtask

  task automatic pulse_swap;
    h_swap = 1'b1;
    @(negedge clk);
    h_swap = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d, e, bad, cnt;
    repeat (3) @(negedge clk);
    chk("R7 reset bank", int'(st_bank), 0);
    chk("R7 reset busy", int'(st_busy), 1);
    chk("R7 reset done", int'(st_reload_done), 0);
    rst = 1'b0;
    wait_idle(1000);
    chk("R7 reload done", int'(st_reload_done), 1);
    chk("R8 csum ok after reload", int'(st_csum_ok), 1);

    // R7 R2 R9: both banks hold the ROM image
    for (int a = 0; a < NW; a++) begin
      tgt_rd(a, d);  chk("R2 target image a", d, img_a(a));
      host_rd(1, a, d); chk("R9 host bank1 image a", d, img_a(a));
    end

    // R2: enables qualify access
    tgt_rd(1, d);
    tgt_addr = 2; tgt_cs_n = 1'b0; tgt_cs = 1'b0;
    @(negedge clk);
    chk("R2 hold cs low", int'(tgt_data), img_a(1));
    tgt_cs_n = 1'b1; tgt_cs = 1'b1;
    @(negedge clk);
    chk("R2 hold cs_n high", int'(tgt_data), img_a(1));
    tgt_cs_n = 1'b1; tgt_cs = 1'b0;

    // R3: active-bank write rejected
    host_wr(0, 4, 8'hEE, e);
    chk("R3 err on active write", e, 1);
    tgt_rd(4, d); chk("R3 active unchanged", d, img_a(4));
    host_rd(0, 4, d); chk("R1 host view of active", d, img_a(4));

    // R3: fill inactive bank, target unaffected
    bad = 0;
    for (int a = 0; a < NW; a++) begin
      host_wr(1, a, img_b(a), e);
      if (e != 0) bad++;
    end
    chk("R3 inactive writes accepted", bad, 0);
    bad = 0;
    for (int a = 0; a < NW; a++) begin
      tgt_rd(a, d);
      if (d != img_a(a)) bad++;
    end
    chk("R3 target still old image", bad, 0);

    // R4 R5: swap and resync copy
    pulse_swap();
    chk("R4 swap latched not applied", int'(st_bank), 0);
    @(negedge clk);
    chk("R4 bank toggled", int'(st_bank), 1);
    cnt = 0;
    while (st_busy && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk("R5 copy busy cycles", cnt, 2 * NW);
    for (int a = 0; a < NW; a++) begin
      tgt_rd(a, d);     chk("R2 target new image", d, img_b(a));
      host_rd(0, a, d); chk("R5 stale bank resynced", d, img_b(a));
    end

    // R4: swap held off during a target access
    tgt_addr = 0; tgt_cs_n = 1'b0; tgt_cs = 1'b1;
    pulse_swap();
    repeat (5) @(negedge clk);
    chk("R4 held during target read", int'(st_bank), 1);
    tgt_cs_n = 1'b1; tgt_cs = 1'b0;
    @(negedge clk);
    chk("R4 applied after read", int'(st_bank), 0);

    // R6: swap and host access held off while busy
    pulse_swap();
    host_wr(0, 3, 8'h11, e);
    chk("R6 no err while busy", e, 0);
    bad = 0;
    while (st_busy && bad < 1000) begin
      if (st_bank != 1'b0) bad = 5000;
      @(negedge clk);
      bad++;
    end
    chk("R6 bank held while busy", (bad >= 5000) ? 1 : 0, 0);
    @(negedge clk);
    chk("R6 pending swap applied", int'(st_bank), 1);
    wait_idle(1000);
    tgt_rd(3, d); chk("R6 busy write dropped", d, img_b(3));

    // R8: wake verify with matching checksum, no reload
    rom_sel = 1;
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk("R8 verify busy", int'(st_busy), 1);
    host_wr(0, 5, 8'h33, e);
    wait_idle(1000);
    chk("R8 csum ok on wake", int'(st_csum_ok), 1);
    chk("R8 reload_done cleared", int'(st_reload_done), 0);
    host_rd(0, 5, d); chk("R6 write during verify dropped", d, img_b(5));
    bad = 0;
    for (int a = 0; a < NW; a++) begin
      tgt_rd(a, d);
      if (d != img_b(a)) bad++;
    end
    chk("R8 image kept after wake", bad, 0);

    // R7: second cold start loads the other ROM image into both banks
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wait_idle(1000);
    chk("R7 bank after reset", int'(st_bank), 0);
    bad = 0;
    for (int a = 0; a < NW; a++) begin
      tgt_rd(a, d);     if (d != img_c(a)) bad++;
      host_rd(1, a, d); if (d != img_c(a)) bad++;
    end
    chk("R7 reload both banks", bad, 0);

    finish_run();
  end
endmodule